// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block tells an external memory array when to restore a row and which row to restore, so that no row goes longer than one retention window without a refresh. An internal pointer names the next row in line. The pointer moves forward only when the array arbiter grants a refresh that the block is requesting. After the last row it wraps back to row 0.

Two policies can be selected. In the spread policy, one row becomes due each time a short interval ends. That interval is the retention window divided by the number of rows. In the block policy, the whole array becomes due once per window, and the rows are requested back to back with no gap. Work that is due but not yet granted builds up in an internal ledger. When a new interval ends while earlier work is still outstanding, that refresh has been postponed. If too many refreshes are postponed in a row, a sticky deadline flag is raised.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is low, and right after it is released, `refresh_req` is 0, `refresh_row` is 0 and `deadline_miss` is 0.
- R2: With `mode_burst` = 0 (spread policy), one row becomes due every `INTERVAL_CYC` clock cycles. `refresh_req` is 1 in the cycle after the interval ends.
- R3: With `mode_burst` = 1 (block policy), `ROWS` rows become due every `ROWS*INTERVAL_CYC` cycles. `refresh_req` stays 1 across back-to-back grants until all owed rows are done.
- R4: Once raised, `refresh_req` stays 1 until a grant is seen. `refresh_row` does not change while the request is waiting.
- R5: When `refresh_grant` is 1 in a cycle where `refresh_req` is 1, exactly one row is done. In the next cycle `refresh_row` is one higher, and it wraps from `ROWS-1` to 0.
- R6: A grant in a cycle where `refresh_req` is 0 has no effect. The row stays the same and no request follows from it.
- R7: An interval end that arrives while work is still owed counts as one postponement. The count returns to 0 when the owed work is fully drained. When the count goes above `POSTPONE_LIMIT`, `deadline_miss` becomes 1 one cycle later and stays 1 until reset.
- R8: A change of `mode_burst` restarts the interval timer from zero. The next row (or array) becomes due one full period of the new policy after the change.
- R9: An interval end in the same cycle as the grant that finishes the last owed row is not a postponement. `refresh_req` stays 1 for the newly due work.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_burst | input | 1 | Policy select: 0 = spread (one row per interval), 1 = block (whole array per window) |
| refresh_grant | input | 1 | Arbiter grant; completes one row when seen together with a request |
| refresh_req | output | 1 | A row refresh is owed |
| refresh_row | output | $clog2(ROWS) | Row to refresh next; stable while the request is waiting |
| deadline_miss | output | 1 | Sticky flag: postponements went above the limit |

## Verification
The delicate case is the cycle in which the timer ends an interval and the arbiter grants the last owed row at the same edge. A new row becomes due and the ledger is drained in that same cycle. The bench provokes this by waiting for the request to rise, holding the grant off for exactly one interval less one cycle, and then granting. It judges the result by the request staying high and by the exact cycle in which `deadline_miss` later rises once grants stop. If the collision were wrongly counted as a postponement, the flag would rise one full interval earlier.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

   // Refresh policy: spread one row per interval, or the whole array per window
   typedef enum logic {
      POL_SPREAD = 1'b0,
      POL_BLOCK  = 1'b1
   } refsch_policy_e;

   // Bits needed to hold owed rows: room for the limit plus a few extra windows
   function automatic int unsigned owed_bits(input int unsigned rows,
                                             input int unsigned limit);
      return $clog2(rows * (limit + 3) + 1);
   endfunction

   // Bits needed for a postponement count that saturates just above the limit
   function automatic int unsigned post_bits(input int unsigned limit);
      return $clog2(limit + 2);
   endfunction

endpackage

// File: rtl/refsch_timer.sv
module refsch_timer
   import refsch_pkg::*;
#(
   parameter int unsigned ROWS         = 8192,
   parameter int unsigned INTERVAL_CYC = 781
) (
   input  logic           clk,
   input  logic           rst_n,
   input  refsch_policy_e policy,
   output logic           tick
);

   localparam int unsigned WINDOW_CYC = INTERVAL_CYC * ROWS;
   localparam int unsigned TW         = $clog2(WINDOW_CYC);
   localparam logic [TW-1:0] SPREAD_LAST = TW'(INTERVAL_CYC - 1);
   localparam logic [TW-1:0] BLOCK_LAST  = TW'(WINDOW_CYC - 1);

   logic [TW-1:0]  cnt_q;
   logic [TW-1:0]  last;
   refsch_policy_e pol_q;
   logic           changed;

   always_comb begin
      last    = (policy == POL_BLOCK) ? BLOCK_LAST : SPREAD_LAST;
      changed = (policy != pol_q);
      tick    = !changed && (cnt_q == last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pol_q <= POL_SPREAD;
      end else begin
         pol_q <= policy;
         if (changed || tick)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/refsch_rowptr.sv
module refsch_rowptr #(
   parameter int unsigned ROWS = 8192,
   localparam int unsigned RW  = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [RW-1:0] row
);

   localparam bit POW2 = ((1 << RW) == ROWS);
   localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

   logic [RW-1:0] row_q;

   generate
      if (POW2) begin : g_natural_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               row_q <= '0;
            else if (adv)
               row_q <= row_q + 1'b1;
         end
      end else begin : g_compare_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               row_q <= '0;
            else if (adv)
               row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
         end
      end
   endgenerate

   assign row = row_q;

endmodule

// File: rtl/refsch_ledger.sv
module refsch_ledger
   import refsch_pkg::*;
#(
   parameter int unsigned ROWS           = 8192,
   parameter int unsigned POSTPONE_LIMIT = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  refsch_policy_e policy,
   input  logic           tick,
   input  logic           grant,
   output logic           req,
   output logic           miss
);

   localparam int unsigned OW = owed_bits(ROWS, POSTPONE_LIMIT);
   localparam int unsigned PW = post_bits(POSTPONE_LIMIT);
   localparam logic [OW-1:0] OWED_MAX  = '1;
   localparam logic [OW-1:0] ADD_BLOCK = OW'(ROWS);
   localparam logic [OW-1:0] ONE_ROW   = OW'(1);
   localparam logic [PW-1:0] POST_MAX  = PW'(POSTPONE_LIMIT + 1);
   localparam logic [PW-1:0] POST_LIM  = PW'(POSTPONE_LIMIT);

   logic [OW-1:0] owed_q, owed_d, add, sat;
   logic [OW:0]   sum;
   logic [PW-1:0] post_q, post_d;
   logic          miss_q;
   logic          busy, done, late;

   always_comb begin
      busy = (owed_q != '0);
      done = grant && busy;
      if (!tick)
         add = '0;
      else if (policy == POL_BLOCK)
         add = ADD_BLOCK;
      else
         add = ONE_ROW;
      sum    = {1'b0, owed_q} + {1'b0, add};
      sat    = sum[OW] ? OWED_MAX : sum[OW-1:0];
      owed_d = sat - {{(OW-1){1'b0}}, done};
      // a deadline collides with outstanding work unless that work ends now
      late   = tick && busy && !(done && owed_q == ONE_ROW);
      if (owed_d == '0)
         post_d = '0;
      else if (late && post_q != POST_MAX)
         post_d = post_q + 1'b1;
      else
         post_d = post_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owed_q <= '0;
         post_q <= '0;
         miss_q <= 1'b0;
      end else begin
         owed_q <= owed_d;
         post_q <= post_d;
         miss_q <= miss_q | (post_q > POST_LIM);
      end
   end

   assign req  = busy;
   assign miss = miss_q;

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
   import refsch_pkg::*;
#(
   parameter int unsigned CLK_HZ         = 100_000_000,
   parameter int unsigned WINDOW_MS      = 64,
   parameter int unsigned ROWS           = 8192,
   parameter int unsigned INTERVAL_CYC   = (CLK_HZ / 1000) * WINDOW_MS / ROWS,
   parameter int unsigned POSTPONE_LIMIT = 8,
   localparam int unsigned RW            = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_burst,
   input  logic          refresh_grant,
   output logic          refresh_req,
   output logic [RW-1:0] refresh_row,
   output logic          deadline_miss
);

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("refresh_scheduler: ROWS must be at least 2");
      end
      if (INTERVAL_CYC < 2) begin : g_bad_interval
         $error("refresh_scheduler: INTERVAL_CYC must be at least 2");
      end
   endgenerate

   refsch_policy_e w_policy;
   logic           w_tick;
   logic           w_adv;

   assign w_policy = refsch_policy_e'(mode_burst);
   assign w_adv    = refresh_req && refresh_grant;

   refsch_timer #(
      .ROWS         (ROWS),
      .INTERVAL_CYC (INTERVAL_CYC)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .policy (w_policy),
      .tick   (w_tick)
   );

   refsch_ledger #(
      .ROWS           (ROWS),
      .POSTPONE_LIMIT (POSTPONE_LIMIT)
   ) u_ledger (
      .clk    (clk),
      .rst_n  (rst_n),
      .policy (w_policy),
      .tick   (w_tick),
      .grant  (refresh_grant),
      .req    (refresh_req),
      .miss   (deadline_miss)
   );

   refsch_rowptr #(
      .ROWS (ROWS)
   ) u_rowptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (w_adv),
      .row   (refresh_row)
   );

endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
   parameter int unsigned ROWS = 8192,
   localparam int unsigned RW  = $clog2(ROWS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          grant,
   input logic          req,
   input logic [RW-1:0] row,
   input logic          miss,
   input logic          tick
);

   localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

   // R4: a waiting request is not withdrawn
   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !grant) |=> req);

   // R4: the row is frozen while the request waits
   a_r4_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !grant) |=> $stable(row));

   // R5: a granted request steps the row by one, wrapping at the end
   a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      (req && grant) |=> (row == (($past(row) == LAST_ROW) ? '0 : RW'($past(row) + RW'(1)))));

   // R6: without a request the row never moves
   a_r6_idle_row: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> $stable(row));

   // R2: every interval end leaves work owed
   a_r2_tick_raises: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> req);

   // R7: the deadline flag is sticky
   a_r7_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> miss);

endmodule

bind refresh_scheduler refsch_chk #(.ROWS(ROWS)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .grant (refresh_grant),
   .req   (refresh_req),
   .row   (refresh_row),
   .miss  (deadline_miss),
   .tick  (w_tick)
);

// File: tb/test_refresh_scheduler.sv
`timescale 1ns/1ps
module test_refresh_scheduler;

   localparam int ROWS = 4;
   localparam int IV   = 8;
   localparam int LIM  = 1;
   localparam int RW   = 2;
   localparam int WIN  = ROWS * IV;

   typedef struct packed {
      logic       mode;
      logic [7:0] gdel;
      logic [9:0] cyc;
      logic       miss;
   } vec_t;

   // mode, grant delay, run cycles, expected final deadline flag
   localparam vec_t VT [6] = '{
      '{1'b0, 8'd0,   10'd80,  1'b0},
      '{1'b0, 8'd5,   10'd80,  1'b0},
      '{1'b0, 8'd10,  10'd80,  1'b1},
      '{1'b0, 8'd255, 10'd60,  1'b1},
      '{1'b1, 8'd0,   10'd140, 1'b0},
      '{1'b1, 8'd20,  10'd200, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_burst = 1'b0;
   logic          grant = 1'b0;
   logic          req;
   logic [RW-1:0] row;
   logic          miss;

   int nchk = 0;
   int nfail = 0;
   logic drv_en = 1'b0;
   int   gdel = 0;
   int   wcnt = 0;

   always #5 clk = ~clk;

   refresh_scheduler #(
      .ROWS           (ROWS),
      .INTERVAL_CYC   (IV),
      .POSTPONE_LIMIT (LIM)
   ) i_refresh_scheduler (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_burst    (mode_burst),
      .refresh_grant (grant),
      .refresh_req   (req),
      .refresh_row   (row),
      .deadline_miss (miss)
   );

   // Reference model built from the requirements
   int   m_tmr, m_owed, m_post, m_row;
   logic m_miss, m_mode_q;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tmr <= 0; m_owed <= 0; m_post <= 0; m_row <= 0;
         m_miss <= 1'b0; m_mode_q <= 1'b0;
      end else begin
         automatic bit chg  = (mode_burst != m_mode_q);
         automatic int last = mode_burst ? WIN - 1 : IV - 1;
         automatic bit tk   = !chg && (m_tmr == last);
         automatic bit dn   = grant && (m_owed != 0);
         automatic int nown = m_owed + (tk ? (mode_burst ? ROWS : 1) : 0) - (dn ? 1 : 0);
         automatic bit lt   = tk && (m_owed != 0) && !(dn && m_owed == 1);
         m_mode_q <= mode_burst;
         m_tmr    <= (chg || tk) ? 0 : m_tmr + 1;
         m_owed   <= nown;
         m_post   <= (nown == 0) ? 0 : ((lt && m_post < LIM + 1) ? m_post + 1 : m_post);
         m_miss   <= m_miss | (m_post > LIM);
         if (dn) m_row <= (m_row + 1) % ROWS;
      end
   end

   // Automatic grant driver: grants after gdel waiting cycles of a request
   always @(negedge clk) begin
      if (drv_en) begin
         if (req) begin
            if (wcnt >= gdel) begin grant <= 1'b1; wcnt <= 0; end
            else begin grant <= 1'b0; wcnt <= wcnt + 1; end
         end else begin
            grant <= 1'b0; wcnt <= 0;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic m);
      drv_en = 1'b0;
      grant  = 1'b0;
      wcnt   = 0;
      mode_burst = m;
      rst_n  = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 req in reset", req, 0);
      chk("R1 row in reset", row, 0);
      chk("R1 miss in reset", miss, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 10);
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      // Table-driven runs compared against the reference model every cycle
      for (int i = 0; i < 6; i++) begin
         do_reset(VT[i].mode);
         gdel   = int'(VT[i].gdel);
         drv_en = 1'b1;
         for (int c = 0; c < int'(VT[i].cyc); c++) begin
            @(negedge clk);
            #1;
            chk(VT[i].mode ? "R3 req block" : "R2 req spread", req, (m_owed != 0) ? 1 : 0);
            chk("R5 row", row, m_row);
            chk("R7 miss", miss, m_miss);
         end
         chk("R7 final miss", miss, VT[i].miss);
      end

      // R6: grant with no request leaves everything untouched
      do_reset(1'b0);
      @(negedge clk);
      grant = 1'b1;
      repeat (2) @(negedge clk);
      grant = 1'b0;
      #1;
      chk("R6 row after stray grant", row, 0);
      chk("R6 req after stray grant", req, 0);

      // R9: interval end coinciding with the last owed grant
      do_reset(1'b0);
      for (int k = 0; k < 20 && !req; k++) @(negedge clk);
      chk("R2 first request", req, 1);
      repeat (7) @(negedge clk);
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      #1;
      chk("R9 req stays high", req, 1);
      chk("R9 row advanced", row, 1);
      repeat (11) @(negedge clk);
      #1;
      chk("R9 no early miss", miss, 0);
      repeat (9) @(negedge clk);
      #1;
      chk("R7 miss after postponements", miss, 1);

      // R8: policy change restarts the timer
      do_reset(1'b0);
      repeat (5) @(negedge clk);
      mode_burst = 1'b1;
      repeat (32) @(negedge clk);
      #1;
      chk("R8 no request before full window", req, 0);
      repeat (2) @(negedge clk);
      #1;
      chk("R8 request after full window", req, 1);
      chk("R3 row still zero", row, 0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule